// File: doc/BRIEF.md
# Blackjack Dealer Scoring Engine

This block plays the dealer side of a blackjack hand. An operator enters one card at a time. The card value goes on a 4-bit input and the card button is pressed. The block keeps a running score and raises `hit` while it wants another card. It raises `stand` once the score lands between 17 and 21, and it raises `broke` once the score passes 21 with no ace left to soften. Face cards are entered as 10 and an ace is entered as 1.

An ace first counts as eleven, through an extra +10 added after the card itself. A flag remembers that a soft ace is in the hand. If a later card pushes the score past 21, the block subtracts 10 and clears the flag, then judges the score again. A `stand` or `broke` verdict stays visible until the next card arrives. That card starts a new hand: the score and the flags are wiped before the card is added.

Inside, a two-flop button stage turns each press into one event. A datapath holds the score register, an adder whose second operand is chosen from +10, the card and −10, the ace detector and the two threshold comparators. A four-state controller sequences the datapath: wait for a card, add the card, add the ace bonus, then test the score. Reset is synchronous and active high.

Top module: `bj_dealer`

## Requirements
- R1: After reset the score reads 0, `stand` and `broke` are low and `hit` is high.
- R2: Each press of `card_btn` enters exactly one card, however long the button is held; the card value must be steady from the press until the card is added.
- R3: A card whose value is not 1 (or a 1 while a soft ace is already held) adds its value to the score.
- R4: A card of value 1 entered while no soft ace is held adds 11 in total and marks the hand as holding a soft ace.
- R5: When a judged score is above 16 and at most 21, `stand` rises and `hit` falls; `stand` and `broke` are never high together.
- R6: When a judged score is above 21 and a soft ace is held, 10 is subtracted, the soft-ace mark is cleared and the new score is judged again.
- R7: When a judged score is above 21 and no soft ace is held, `broke` rises and `hit` falls, with the score left showing the bust total.
- R8: When a judged score is 16 or less, the block returns to waiting with `hit` high and both verdicts low.
- R9: A card entered while `stand` or `broke` is high first clears the score, both verdicts and the soft-ace mark, then adds that card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| card_val | input | 4 | Value of the card being entered (ace = 1, face = 10) |
| card_btn | input | 1 | Card-entry button, unsynchronised level |
| score | output | 5 | Running score of the hand |
| hit | output | 1 | High while waiting and wanting another card |
| stand | output | 1 | Hand finished between 17 and 21 |
| broke | output | 1 | Hand finished above 21 |

## Verification
Hands are chosen so that each path through the test state is taken on its own. The ace, 2, 9, 10 hand separates the ace bonus, the soft-ace downgrade and the final bust. A hand of two aces shows that only the first ace gets the bonus. A 16 followed by an ace lands on a bonus, an overshoot and a downgrade to exactly 17. Boundary hands stop at 16 and at 21 to pin both comparators. One long press tells a level-triggered button apart from an edge-triggered one, and a reset in mid-hand shows that state is dropped.

// File: rtl/bj_pkg.sv
package bj_pkg;

  typedef enum logic [1:0] {
    ST_GET  = 2'b00,
    ST_ADD  = 2'b01,
    ST_TEST = 2'b10,
    ST_USE  = 2'b11
  } dealer_state_t;

  typedef enum logic [1:0] {
    OP_PLUS_TEN  = 2'b00,
    OP_CARD      = 2'b01,
    OP_MINUS_TEN = 2'b10,
    OP_NONE      = 2'b11
  } operand_sel_t;

endpackage

// File: rtl/bj_btn_edge.sv
module bj_btn_edge (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press_pulse
);
  logic sync_q;
  logic dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      sync_q <= btn_raw;
      dly_q  <= sync_q;
    end
  end

  assign press_pulse = sync_q & ~dly_q;

  // one event per press: the pulse never lasts two cycles
  assert_single_event_R2: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);

endmodule

// File: rtl/bj_datapath.sv
module bj_datapath
  import bj_pkg::*;
#(
  parameter int SCORE_W     = 5,
  parameter int CARD_W      = 4,
  parameter int ACE_VALUE   = 1,
  parameter int BONUS       = 10,
  parameter int STAND_ABOVE = 16,
  parameter int BUST_ABOVE  = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  operand_sel_t       sel,
  input  logic               load,
  input  logic               clear,
  input  logic [CARD_W-1:0]  card,
  output logic [SCORE_W-1:0] score_q,
  output logic               is_ace,
  output logic               gt_stand,
  output logic               gt_bust
);
  localparam logic [SCORE_W-1:0] PLUS_K  = SCORE_W'(BONUS);
  localparam logic [SCORE_W-1:0] MINUS_K = ~PLUS_K + 1'b1;
  localparam int                 PAD_W   = SCORE_W - CARD_W;

  logic [SCORE_W-1:0] operand;
  logic [SCORE_W-1:0] sum;

  always_comb begin
    case (sel)
      OP_PLUS_TEN:  operand = PLUS_K;
      OP_CARD:      operand = {{PAD_W{1'b0}}, card};
      OP_MINUS_TEN: operand = MINUS_K;
      default:      operand = '0;
    endcase
  end

  assign sum = score_q + operand;

  always_ff @(posedge clk) begin
    if (rst || clear) score_q <= '0;
    else if (load)    score_q <= sum;
  end

  assign is_ace   = (card == CARD_W'(ACE_VALUE));
  assign gt_stand = (score_q > SCORE_W'(STAND_ABOVE));
  assign gt_bust  = (score_q > SCORE_W'(BUST_ABOVE));

  // a new hand starts from an empty score
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (score_q == '0));

endmodule

// File: rtl/bj_ctrl.sv
module bj_ctrl
  import bj_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         new_card,
  input  logic         is_ace,
  input  logic         gt_stand,
  input  logic         gt_bust,
  output operand_sel_t sel,
  output logic         load,
  output logic         clear,
  output logic         hit,
  output logic         stand,
  output logic         broke
);
  dealer_state_t state_q, state_n;
  logic ace11_q, ace11_n;
  logic stand_q, stand_n;
  logic broke_q, broke_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_GET;
      ace11_q <= 1'b0;
      stand_q <= 1'b0;
      broke_q <= 1'b0;
    end else begin
      state_q <= state_n;
      ace11_q <= ace11_n;
      stand_q <= stand_n;
      broke_q <= broke_n;
    end
  end

  always_comb begin
    state_n = state_q;
    ace11_n = ace11_q;
    stand_n = stand_q;
    broke_n = broke_q;
    sel     = OP_CARD;
    load    = 1'b0;
    clear   = 1'b0;
    case (state_q)
      ST_GET: begin
        if (new_card) begin
          if (stand_q || broke_q) begin
            clear   = 1'b1;
            stand_n = 1'b0;
            broke_n = 1'b0;
            ace11_n = 1'b0;
          end
          state_n = ST_ADD;
        end
      end
      ST_ADD: begin
        sel     = OP_CARD;
        load    = 1'b1;
        state_n = (is_ace && !ace11_q) ? ST_USE : ST_TEST;
      end
      ST_USE: begin
        sel     = OP_PLUS_TEN;
        load    = 1'b1;
        ace11_n = 1'b1;
        state_n = ST_TEST;
      end
      default: begin
        if (gt_bust) begin
          if (ace11_q) begin
            sel     = OP_MINUS_TEN;
            load    = 1'b1;
            ace11_n = 1'b0;
          end else begin
            broke_n = 1'b1;
            state_n = ST_GET;
          end
        end else begin
          if (gt_stand) stand_n = 1'b1;
          state_n = ST_GET;
        end
      end
    endcase
  end

  assign hit   = (state_q == ST_GET) && !stand_q && !broke_q;
  assign stand = stand_q;
  assign broke = broke_q;

  assert_ace_upgrade_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_USE) |=> (state_q == ST_TEST && ace11_q));

  assert_verdict_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(stand_q && broke_q));

  assert_soft_retest_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEST && gt_bust && ace11_q) |=> (state_q == ST_TEST && !ace11_q));

  assert_low_return_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEST && !gt_stand) |=> (state_q == ST_GET && !stand_q && !broke_q));

endmodule

// File: rtl/bj_dealer.sv
module bj_dealer
  import bj_pkg::*;
#(
  parameter int SCORE_W     = 5,
  parameter int CARD_W      = 4,
  parameter int STAND_ABOVE = 16,
  parameter int BUST_ABOVE  = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CARD_W-1:0]  card_val,
  input  logic               card_btn,
  output logic [SCORE_W-1:0] score,
  output logic               hit,
  output logic               stand,
  output logic               broke
);
  operand_sel_t sel;
  logic new_card, load, clear, is_ace, gt_stand, gt_bust;

  bj_btn_edge u_btn (
    .clk         (clk),
    .rst         (rst),
    .btn_raw     (card_btn),
    .press_pulse (new_card)
  );

  bj_datapath #(
    .SCORE_W     (SCORE_W),
    .CARD_W      (CARD_W),
    .ACE_VALUE   (1),
    .BONUS       (10),
    .STAND_ABOVE (STAND_ABOVE),
    .BUST_ABOVE  (BUST_ABOVE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .load     (load),
    .clear    (clear),
    .card     (card_val),
    .score_q  (score),
    .is_ace   (is_ace),
    .gt_stand (gt_stand),
    .gt_bust  (gt_bust)
  );

  bj_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .new_card (new_card),
    .is_ace   (is_ace),
    .gt_stand (gt_stand),
    .gt_bust  (gt_bust),
    .sel      (sel),
    .load     (load),
    .clear    (clear),
    .hit      (hit),
    .stand    (stand),
    .broke    (broke)
  );

  assert_stand_range_R5: assert property (@(posedge clk) disable iff (rst)
    stand |-> (score > SCORE_W'(STAND_ABOVE) && score <= SCORE_W'(BUST_ABOVE)));

  assert_broke_bust_R7: assert property (@(posedge clk) disable iff (rst)
    broke |-> (score > SCORE_W'(BUST_ABOVE)));

endmodule

// File: tb/bj_dealer_bench.sv
module bj_dealer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] card_val = 4'd0;
  logic       card_btn = 1'b0;
  logic [4:0] score;
  logic       hit, stand, broke;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit started = 1'b0;
  bit done = 1'b0;

  // behavioural reference: 0 wait, 1 add, 2 test, 3 bonus
  int m_st = 0, m_score = 0;
  bit m_soft = 0, m_stand = 0, m_broke = 0, m_sync = 0, m_dly = 0;

  always #10ns clk = ~clk;

  bj_dealer u_bj_dealer (
    .clk(clk), .rst(rst), .card_val(card_val), .card_btn(card_btn),
    .score(score), .hit(hit), .stand(stand), .broke(broke)
  );

  always @(posedge clk) begin
    bit evt;
    started <= 1'b1;
    if (rst) begin
      m_st = 0; m_score = 0; m_soft = 0; m_stand = 0; m_broke = 0;
      m_sync = 0; m_dly = 0;
    end else begin
      evt = m_sync && !m_dly;
      m_dly = m_sync;
      m_sync = card_btn;
      case (m_st)
        0: if (evt) begin
             if (m_stand || m_broke) begin
               m_score = 0; m_stand = 0; m_broke = 0; m_soft = 0;
             end
             m_st = 1;
           end
        1: begin
             m_score = (m_score + card_val) % 32;
             m_st = (card_val == 1 && !m_soft) ? 3 : 2;
           end
        3: begin
             m_score = (m_score + 10) % 32;
             m_soft = 1;
             m_st = 2;
           end
        default: begin
             if (m_score > 21) begin
               if (m_soft) begin m_score = m_score - 10; m_soft = 0; end
               else begin m_broke = 1; m_st = 0; end
             end else begin
               if (m_score > 16) m_stand = 1;
               m_st = 0;
             end
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      int ehit;
      ehit = (m_st == 0 && !m_stand && !m_broke) ? 1 : 0;
      n_cmp++;
      if (score != m_score[4:0] || hit != ehit[0] || stand != m_stand || broke != m_broke) begin
        n_bad++;
        $display("FAIL %s cycle compare: actual score=%0d hit=%0b stand=%0b broke=%0b expected score=%0d hit=%0d stand=%0b broke=%0b",
                 cur_req, score, hit, stand, broke, m_score, ehit, m_stand, m_broke);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic play(input int v, input int hold);
    @(negedge clk);
    card_val = 4'(v);
    card_btn = 1'b1;
    repeat (hold) @(negedge clk);
    card_btn = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 score", score, 0); chk("R1 hit", hit, 1);
    chk("R1 verdicts", {stand, broke}, 0);

    cur_req = "R4";
    play(1, 3);  chk("R4 ace counts eleven", score, 11);
    cur_req = "R3";
    play(2, 3);  chk("R3 add two", score, 13);
    cur_req = "R6";
    play(9, 3);  chk("R6 soft ace downgraded", score, 12); chk("R6 hit", hit, 1);
    cur_req = "R7";
    play(10, 3); chk("R7 bust score", score, 22); chk("R7 broke", broke, 1);
    chk("R7 hit low", hit, 0);

    cur_req = "R9";
    play(5, 3);  chk("R9 cleared before add", score, 5); chk("R9 broke cleared", broke, 0);
    cur_req = "R8";
    play(7, 3);  chk("R8 twelve keeps hitting", hit, 1);
    cur_req = "R5";
    play(6, 3);  chk("R5 stand at 18", stand, 1); chk("R5 hit low", hit, 0);

    cur_req = "R4";
    play(1, 3);  chk("R4 first ace new hand", score, 11);
    play(1, 3);  chk("R4 second ace counts one", score, 12);
    cur_req = "R6";
    play(10, 3); chk("R6 downgrade after two aces", score, 12);
    cur_req = "R5";
    play(9, 3);  chk("R5 stand at 21", stand, 1); chk("R5 score 21", score, 21);

    cur_req = "R8";
    play(10, 3); play(6, 3);
    chk("R8 sixteen hits", hit, 1); chk("R8 no stand at 16", stand, 0);
    cur_req = "R6";
    play(1, 3);  chk("R6 bonus then downgrade to 17", score, 17); chk("R6 stands", stand, 1);

    cur_req = "R2";
    play(3, 25); chk("R2 long press adds once", score, 3);
    play(4, 1);  chk("R2 short press", score, 7);

    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 mid-hand reset score", score, 0); chk("R1 mid-hand reset hit", hit, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule